// File: doc/BRIEF.md
# Floating-Point Conditional Trap Evaluator

This block decides whether a conditional floating-point trap instruction fires. A single-cycle evaluate strobe captures a 5-bit condition selector. On the same cycle the block samples four floating-point condition flags: negative, zero, infinity and not-a-number. It also samples five exception status flags. One cycle after the strobe, the block gives exactly one result. It either raises a trap request, or it raises a continue pulse so that the next instruction can proceed.

The comparison conditions fall into two groups. Some comparisons tolerate an unordered result. Others do not tolerate one, and this group also includes the infinity tests. When a condition from the intolerant group is found true while the not-a-number flag is set, the block sets two sticky flags: unordered-condition and software-interrupt. Each sticky flag clears only on its own clear input. The stack request, which lets the status register be saved, comes one cycle after the trap request. By then both sticky flags already hold their new values.

When the trap fires in long-service mode, the new interrupt priority output becomes all ones. In every other case it takes the priority supplied on the input.

Top module: `fptrap_eval`

## Requirements
- R1: Selector codes 0 EQ, 9 MI, 10 NE, 6 INF, 15 NINF, 18 OR, 19 PL and 20 UN are true for, respectively: Z=1, N=1, Z=0, I=1, I=0, NAN=0, N=0 and NAN=1.
- R2: Selector codes 2 GE, 3 GL, 4 GLE, 5 GT, 7 LE and 8 LT are each true when their expression is 0. The expressions are: NAN|(N&~Z) for GE, NAN|Z for GL, NAN for GLE, NAN|Z|N for GT, NAN|~(N|Z) for LE, and NAN|Z|~N for LT.
- R3: Selector codes 11 NGE, 12 NGL, 13 NGLE, 14 NGT, 16 NLE and 17 NLT are true when the same expressions as R2, in the same order, evaluate to 1.
- R4: Selector code 1 ERR is true when any of these is 1: the sticky unordered flag, SNAN, OPERR, OVF, UNF or DZ. The condition flags do not affect it.
- R5: Each evaluate strobe produces, on the next cycle, a one-cycle pulse on exactly one of trap_o (condition true) or cont_o (condition false).
- R6: Both sticky flags become 1 on the cycle after a strobe only in one case. The condition must be true, it must be one of GE, GL, GLE, GT, INF, LE, LT, NGE, NGL, NGLE, NGT, NINF, NLE or NLT, and NAN must be 1. A false condition or any other code leaves the flags unchanged.
- R7: stack_req_o pulses for one cycle, on the cycle after each trap_o pulse, and at no other time.
- R8: On each strobe, ipl_o takes all ones if the condition is true and long_svc_i is 1. Otherwise it takes ipl_i. It holds that value between strobes.
- R9: Selector codes 21 to 31 are never true. They produce cont_o together with a one-cycle illegal_o pulse.
- R10: A sticky flag clears on the cycle after its clear input is high. A set in the same cycle wins over the clear.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Evaluate strobe, one per instruction |
| cond_sel_i | input | 5 | Condition selector code |
| long_svc_i | input | 1 | Long service routine selected |
| ipl_i | input | 2 | Current interrupt priority level |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_inf_i | input | 1 | Infinity flag |
| flag_nan_i | input | 1 | Not-a-number flag |
| exc_snan_i | input | 1 | Signalling NaN exception status |
| exc_operr_i | input | 1 | Operand error exception status |
| exc_ovf_i | input | 1 | Overflow exception status |
| exc_unf_i | input | 1 | Underflow exception status |
| exc_dz_i | input | 1 | Divide-by-zero exception status |
| uncc_clr_i | input | 1 | Clear the sticky unordered flag |
| siop_clr_i | input | 1 | Clear the sticky software-interrupt flag |
| trap_o | output | 1 | Trap request pulse |
| cont_o | output | 1 | Continue pulse |
| illegal_o | output | 1 | Undefined selector pulse |
| stack_req_o | output | 1 | Status stacking may begin |
| ipl_o | output | 2 | New interrupt priority level |
| uncc_o | output | 1 | Sticky unordered-condition flag |
| siop_o | output | 1 | Sticky software-interrupt flag |

## Verification
The bench builds the block with its default parameters: a 5-bit selector and a 2-bit priority. This makes all 32 selector codes reachable, including the eleven undefined ones. It also lets the long-service priority of 3 be told apart from every value driven on the input. A vector table sets each defined condition both true and false, in several cases with NAN set, so that both groups of conditions and their effect on the flags can be checked. Directed tests then cover ERR driven by each exception input and by the sticky flag, a set and a clear in the same cycle, and the priority output.

// File: rtl/fptrap_pkg.sv
package fptrap_pkg;
    localparam int unsigned CSEL_W   = 5;
    localparam int unsigned NUM_COND = 21;

    typedef enum logic [CSEL_W-1:0] {
        C_EQ = 5'd0,  C_ERR = 5'd1,  C_GE = 5'd2,   C_GL = 5'd3,
        C_GLE = 5'd4, C_GT = 5'd5,   C_INF = 5'd6,  C_LE = 5'd7,
        C_LT = 5'd8,  C_MI = 5'd9,   C_NE = 5'd10,  C_NGE = 5'd11,
        C_NGL = 5'd12, C_NGLE = 5'd13, C_NGT = 5'd14, C_NINF = 5'd15,
        C_NLE = 5'd16, C_NLT = 5'd17, C_OR = 5'd18,  C_PL = 5'd19,
        C_UN = 5'd20
    } cond_e;

    typedef struct packed {
        logic fire;     // condition true
        logic unaware;  // belongs to the group intolerant of unordered
        logic illegal;  // undefined selector
    } cond_res_t;
endpackage

// File: rtl/fptrap_cond.sv
module fptrap_cond
    import fptrap_pkg::*;
(
    input  logic [CSEL_W-1:0] sel_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic              inf_i,
    input  logic              nan_i,
    input  logic              exc_any_i,
    output cond_res_t         res_o
);
    // Shared comparison terms; the negated forms reuse them.
    logic ge_t, gl_t, gle_t, gt_t, le_t, lt_t;
    cond_e code;

    always_comb begin
        ge_t  = nan_i | (n_i & ~z_i);
        gl_t  = nan_i | z_i;
        gle_t = nan_i;
        gt_t  = nan_i | z_i | n_i;
        le_t  = nan_i | ~(n_i | z_i);
        lt_t  = nan_i | z_i | ~n_i;
        code  = cond_e'(sel_i);
        res_o = '0;
        case (code)
            C_EQ:   res_o.fire = z_i;
            C_ERR:  res_o.fire = exc_any_i;
            C_MI:   res_o.fire = n_i;
            C_NE:   res_o.fire = ~z_i;
            C_OR:   res_o.fire = ~nan_i;
            C_PL:   res_o.fire = ~n_i;
            C_UN:   res_o.fire = nan_i;
            C_GE:   res_o = '{fire: ~ge_t,  unaware: 1'b1, illegal: 1'b0};
            C_GL:   res_o = '{fire: ~gl_t,  unaware: 1'b1, illegal: 1'b0};
            C_GLE:  res_o = '{fire: ~gle_t, unaware: 1'b1, illegal: 1'b0};
            C_GT:   res_o = '{fire: ~gt_t,  unaware: 1'b1, illegal: 1'b0};
            C_LE:   res_o = '{fire: ~le_t,  unaware: 1'b1, illegal: 1'b0};
            C_LT:   res_o = '{fire: ~lt_t,  unaware: 1'b1, illegal: 1'b0};
            C_NGE:  res_o = '{fire: ge_t,   unaware: 1'b1, illegal: 1'b0};
            C_NGL:  res_o = '{fire: gl_t,   unaware: 1'b1, illegal: 1'b0};
            C_NGLE: res_o = '{fire: gle_t,  unaware: 1'b1, illegal: 1'b0};
            C_NGT:  res_o = '{fire: gt_t,   unaware: 1'b1, illegal: 1'b0};
            C_NLE:  res_o = '{fire: le_t,   unaware: 1'b1, illegal: 1'b0};
            C_NLT:  res_o = '{fire: lt_t,   unaware: 1'b1, illegal: 1'b0};
            C_INF:  res_o = '{fire: inf_i,  unaware: 1'b1, illegal: 1'b0};
            C_NINF: res_o = '{fire: ~inf_i, unaware: 1'b1, illegal: 1'b0};
            default: res_o.illegal = 1'b1;  // R9: undefined codes never fire
        endcase
    end

    always_comb begin
        if (res_o.illegal) assert (!res_o.fire) else $error("p_illegal_quiet_r9");
    end
endmodule

// File: rtl/fptrap_sticky.sv
module fptrap_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;  // R10: set overrides clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign q_o = flag_q;

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/fptrap_eval.sv
module fptrap_eval
    import fptrap_pkg::*;
#(
    parameter int unsigned IPL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [CSEL_W-1:0] cond_sel_i,
    input  logic              long_svc_i,
    input  logic [IPL_W-1:0]  ipl_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic              flag_inf_i,
    input  logic              flag_nan_i,
    input  logic              exc_snan_i,
    input  logic              exc_operr_i,
    input  logic              exc_ovf_i,
    input  logic              exc_unf_i,
    input  logic              exc_dz_i,
    input  logic              uncc_clr_i,
    input  logic              siop_clr_i,
    output logic              trap_o,
    output logic              cont_o,
    output logic              illegal_o,
    output logic              stack_req_o,
    output logic [IPL_W-1:0]  ipl_o,
    output logic              uncc_o,
    output logic              siop_o
);
    localparam logic [IPL_W-1:0] LONG_IPL = '1;
    localparam int unsigned      N_STICKY = 2;  // 0: unordered, 1: sw interrupt

    typedef struct packed {
        logic             trap;
        logic             cont;
        logic             illegal;
        logic             stack;
        logic [IPL_W-1:0] ipl;
    } ev_state_t;

    ev_state_t st_d, st_q;
    cond_res_t res;
    logic      exc_any;
    logic      sticky_set;
    logic [N_STICKY-1:0] sticky_clr, sticky_q;

    assign exc_any = sticky_q[0] | exc_snan_i | exc_operr_i |
                     exc_ovf_i | exc_unf_i | exc_dz_i;

    fptrap_cond i_cond (
        .sel_i     (cond_sel_i),
        .n_i       (flag_n_i),
        .z_i       (flag_z_i),
        .inf_i     (flag_inf_i),
        .nan_i     (flag_nan_i),
        .exc_any_i (exc_any),
        .res_o     (res)
    );

    assign sticky_set = eval_i & res.fire & res.unaware & flag_nan_i;
    assign sticky_clr = {siop_clr_i, uncc_clr_i};

    for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
        fptrap_sticky i_sticky (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (sticky_set),
            .clr_i (sticky_clr[g]),
            .q_o   (sticky_q[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.trap    = eval_i & res.fire;
        st_d.cont    = eval_i & ~res.fire;
        st_d.illegal = eval_i & res.illegal;
        st_d.stack   = st_q.trap;  // flags settled one cycle earlier
        if (eval_i)
            st_d.ipl = (res.fire && long_svc_i) ? LONG_IPL : ipl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_o      = st_q.trap;
    assign cont_o      = st_q.cont;
    assign illegal_o   = st_q.illegal;
    assign stack_req_o = st_q.stack;
    assign ipl_o       = st_q.ipl;
    assign uncc_o      = sticky_q[0];
    assign siop_o      = sticky_q[1];

    p_one_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_o && cont_o));
    p_result_follows_eval_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eval_i) |-> (trap_o || cont_o));
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o || cont_o) |-> $past(eval_i));
    p_stack_after_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> stack_req_o);
    p_stack_needs_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stack_req_o |-> $past(trap_o));
    p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uncc_o) |-> ($past(eval_i && flag_nan_i) && trap_o));
    p_illegal_continues_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (cont_o && !trap_o));
    p_ipl_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && $past(long_svc_i)) |-> (ipl_o == LONG_IPL));
endmodule

// File: tb/test_fptrap_eval.sv
module test_fptrap_eval;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eval_i = 0, long_svc_i = 0;
    logic [4:0] cond_sel_i = '0;
    logic [1:0] ipl_i = '0;
    logic flag_n_i = 0, flag_z_i = 0, flag_inf_i = 0, flag_nan_i = 0;
    logic exc_snan_i = 0, exc_operr_i = 0, exc_ovf_i = 0, exc_unf_i = 0, exc_dz_i = 0;
    logic uncc_clr_i = 0, siop_clr_i = 0;
    logic trap_o, cont_o, illegal_o, stack_req_o, uncc_o, siop_o;
    logic [1:0] ipl_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    fptrap_eval i_fptrap_eval (.*);

    // {selector, N Z I NAN, expected true, expected sticky set}
    localparam int NV = 42;
    localparam logic [10:0] VEC [NV] = '{
        {5'd0,  4'b0100, 1'b1, 1'b0}, {5'd0,  4'b0000, 1'b0, 1'b0},
        {5'd1,  4'b0000, 1'b0, 1'b0}, {5'd2,  4'b0000, 1'b1, 1'b0},
        {5'd2,  4'b1000, 1'b0, 1'b0}, {5'd2,  4'b0001, 1'b0, 1'b0},
        {5'd3,  4'b0000, 1'b1, 1'b0}, {5'd3,  4'b0100, 1'b0, 1'b0},
        {5'd4,  4'b0000, 1'b1, 1'b0}, {5'd4,  4'b0001, 1'b0, 1'b0},
        {5'd5,  4'b0000, 1'b1, 1'b0}, {5'd5,  4'b1000, 1'b0, 1'b0},
        {5'd6,  4'b0011, 1'b1, 1'b1}, {5'd6,  4'b0000, 1'b0, 1'b0},
        {5'd7,  4'b1000, 1'b1, 1'b0}, {5'd7,  4'b0000, 1'b0, 1'b0},
        {5'd8,  4'b1000, 1'b1, 1'b0}, {5'd8,  4'b1100, 1'b0, 1'b0},
        {5'd9,  4'b1001, 1'b1, 1'b0}, {5'd9,  4'b0000, 1'b0, 1'b0},
        {5'd10, 4'b0001, 1'b1, 1'b0}, {5'd10, 4'b0100, 1'b0, 1'b0},
        {5'd11, 4'b0001, 1'b1, 1'b1}, {5'd11, 4'b0000, 1'b0, 1'b0},
        {5'd12, 4'b0100, 1'b1, 1'b0}, {5'd12, 4'b0001, 1'b1, 1'b1},
        {5'd13, 4'b0000, 1'b0, 1'b0}, {5'd13, 4'b0001, 1'b1, 1'b1},
        {5'd14, 4'b1000, 1'b1, 1'b0}, {5'd14, 4'b0000, 1'b0, 1'b0},
        {5'd15, 4'b0001, 1'b1, 1'b1}, {5'd15, 4'b0010, 1'b0, 1'b0},
        {5'd16, 4'b0000, 1'b1, 1'b0}, {5'd16, 4'b1000, 1'b0, 1'b0},
        {5'd17, 4'b0000, 1'b1, 1'b0}, {5'd17, 4'b1000, 1'b0, 1'b0},
        {5'd18, 4'b0000, 1'b1, 1'b0}, {5'd18, 4'b0001, 1'b0, 1'b0},
        {5'd19, 4'b0001, 1'b1, 1'b0}, {5'd20, 4'b0001, 1'b1, 1'b0},
        {5'd21, 4'b0001, 1'b0, 1'b0}, {5'd31, 4'b0100, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [4:0] s);
        if (s > 5'd20) return "R9";
        if (s == 5'd1) return "R4";
        if (s inside {5'd0, 5'd6, 5'd9, 5'd10, 5'd15, 5'd18, 5'd19, 5'd20}) return "R1";
        if (s >= 5'd11) return "R3";
        return "R2";
    endfunction

    // Strobe one evaluation; returns with outputs of that evaluation visible.
    task automatic strobe(input logic [4:0] s, input logic [3:0] f);
        @(negedge clk);
        cond_sel_i = s;
        {flag_n_i, flag_z_i, flag_inf_i, flag_nan_i} = f;
        eval_i = 1'b1;
        @(negedge clk);
        eval_i = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        uncc_clr_i = 1'b1; siop_clr_i = 1'b1;
        @(negedge clk);
        uncc_clr_i = 1'b0; siop_clr_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "trap in reset", int'(trap_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "outputs after reset",
            int'({trap_o, cont_o, illegal_o, stack_req_o, ipl_o, uncc_o, siop_o}), 0);

        // Table of conditions
        for (int k = 0; k < NV; k++) begin
            logic [4:0] s;
            logic [3:0] f;
            logic ef, es;
            {s, f, ef, es} = VEC[k];
            strobe(s, f);
            chk(tag_of(s), $sformatf("fire sel=%0d flags=%b", s, f), int'(trap_o), int'(ef));
            chk("R5", "continue pulse", int'(cont_o), int'(!ef));
            chk("R9", "illegal flag", int'(illegal_o), int'(s > 5'd20));
            chk("R6", $sformatf("unordered flag sel=%0d", s), int'(uncc_o), int'(es));
            chk("R6", "sw interrupt flag", int'(siop_o), int'(es));
            @(negedge clk);
            chk("R7", "stack request", int'(stack_req_o), int'(ef));
            chk("R5", "pulse width", int'(trap_o | cont_o), 0);
            clear_flags();
        end

        // ERR from each exception input
        for (int b = 0; b < 5; b++) begin
            {exc_snan_i, exc_operr_i, exc_ovf_i, exc_unf_i, exc_dz_i} = 5'b10000 >> b;
            strobe(5'd1, 4'b1111);
            chk("R4", $sformatf("ERR with exception bit %0d", b), int'(trap_o), 1);
            chk("R6", "ERR leaves flags", int'(uncc_o), 0);
        end
        {exc_snan_i, exc_operr_i, exc_ovf_i, exc_unf_i, exc_dz_i} = '0;
        strobe(5'd1, 4'b1111);
        chk("R4", "ERR ignores condition flags", int'(trap_o), 0);

        // ERR from the sticky unordered flag; set together with clear (R10)
        @(negedge clk);
        uncc_clr_i = 1'b1; siop_clr_i = 1'b1;
        strobe(5'd13, 4'b0001);
        uncc_clr_i = 1'b0; siop_clr_i = 1'b0;
        chk("R10", "set beats clear (unordered)", int'(uncc_o), 1);
        chk("R10", "set beats clear (sw interrupt)", int'(siop_o), 1);
        strobe(5'd0, 4'b0101);
        chk("R6", "aware condition keeps flag", int'(uncc_o), 1);
        strobe(5'd1, 4'b0000);
        chk("R4", "ERR from sticky flag", int'(trap_o), 1);
        @(negedge clk);
        siop_clr_i = 1'b1;
        @(negedge clk);
        siop_clr_i = 1'b0;
        chk("R10", "separate clear", int'(siop_o), 0);
        chk("R10", "other flag kept", int'(uncc_o), 1);
        clear_flags();
        chk("R10", "cleared", int'(uncc_o), 0);

        // Priority output
        ipl_i = 2'd1; long_svc_i = 1'b1;
        strobe(5'd0, 4'b0100);
        chk("R8", "long service trap", int'(ipl_o), 3);
        ipl_i = 2'd2; long_svc_i = 1'b1;
        strobe(5'd0, 4'b0000);
        chk("R8", "false condition keeps input", int'(ipl_o), 2);
        ipl_i = 2'd1; long_svc_i = 1'b0;
        strobe(5'd19, 4'b0000);
        chk("R8", "short service trap", int'(ipl_o), 1);
        ipl_i = 2'd0;
        @(negedge clk);
        chk("R8", "held between strobes", int'(ipl_o), 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule